// File: doc/BRIEF.md
# Time-Multiplexed Scheduled Switch

A two-input, two-output switching node for an overlay network whose traffic is routed entirely ahead of time. No address or header is ever inspected. Before operation, a small context memory is filled with one entry per slot of a repeating schedule. Each entry holds, for each output, a select bit that picks one of the two inputs and a valid bit that marks the slot as carrying a word.

Once the run-enable input is raised, a slot counter steps through the schedule one entry per clock and wraps back to the first slot after the last one. On every clock, each output register loads the input named by the current entry, and its valid flag loads that entry's valid bit. A word therefore leaves the switch one cycle after it enters. There is no backpressure. The schedule itself must ensure that no two words compete for the same output in the same slot.

Top module: `tmx_sched_switch`

## Requirements
- R1: After reset, both output valid flags are low, both output data buses are zero, the slot index is zero, and every context entry is zero.
- R2: While run_en is low, a cycle with cfg_we high writes cfg_data into the entry at cfg_addr. The entry bits are: bit 0 is the select for output 0, bit 1 is the valid for output 0, bit 2 is the select for output 1, and bit 3 is the valid for output 1.
- R3: A configuration write made while run_en is high has no effect on any context entry.
- R4: While run_en is low, the slot index is held at zero. While run_en is high, the slot index advances by one on each clock.
- R5: When the slot index equals SCHED_LEN-1 and run_en is high, the next slot index is zero, and the schedule then repeats.
- R6: When run_en is high at a clock edge, each output data register loads in0_data if its select bit in the current entry is 0, or in1_data if that bit is 1. The new value is visible one cycle after the input was sampled.
- R7: Each output valid flag takes its valid bit from the current entry one cycle later. Both valid flags are low on the cycle after any edge at which run_en was low, and the output data holds its value on that cycle.
- R8: Both outputs may select the same input in the same slot, so one input word can be copied to both outputs.
- R9: A configuration write to an address at or above SCHED_LEN changes no entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | High to step the schedule; low to hold the schedule and allow configuration |
| cfg_we | input | 1 | Context write strobe |
| cfg_addr | input | CNT_W | Context entry address |
| cfg_data | input | 4 | Context entry value: {vld1, sel1, vld0, sel0} |
| in0_data | input | DATA_W | Input port 0 word |
| in1_data | input | DATA_W | Input port 1 word |
| out0_data | output | DATA_W | Output port 0 word |
| out0_valid | output | 1 | Output port 0 carries a scheduled word |
| out1_data | output | DATA_W | Output port 1 word |
| out1_valid | output | 1 | Output port 1 carries a scheduled word |
| slot_idx | output | CNT_W | Schedule slot that the next clock edge uses |

## Verification
The data and valid outputs are due exactly one clock after the edge at which the inputs and the current slot's entry are sampled. The slot index shows, between edges, the entry that the next edge will use. The bench drives every input on the falling edge. At that point it computes the expected outputs from its own copy of the schedule and its own slot count, then compares them on the following falling edge, after exactly one rising edge has passed. Configuration writes update the bench's copy only when run_en is low and the address is in range, so ignored writes appear as outputs that do not change in later slots.

// File: rtl/tmx_sched_switch.sv
module tmx_sched_switch #(
  parameter int DATA_W    = 16,
  parameter int SCHED_LEN = 6,
  localparam int CNT_W    = (SCHED_LEN > 1) ? $clog2(SCHED_LEN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic              cfg_we,
  input  logic [CNT_W-1:0]  cfg_addr,
  input  logic [3:0]        cfg_data,
  input  logic [DATA_W-1:0] in0_data,
  input  logic [DATA_W-1:0] in1_data,
  output logic [DATA_W-1:0] out0_data,
  output logic              out0_valid,
  output logic [DATA_W-1:0] out1_data,
  output logic              out1_valid,
  output logic [CNT_W-1:0]  slot_idx
);
  localparam int          ENT_W = 4;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SCHED_LEN - 1);

  logic [ENT_W*SCHED_LEN-1:0] ctx_flat;
  logic [CNT_W-1:0]           slot_q;
  logic [ENT_W-1:0]           cur_ent;
  logic                       addr_ok;

  assign addr_ok  = {1'b0, cfg_addr} < (CNT_W+1)'(SCHED_LEN);
  assign cur_ent  = ctx_flat[{slot_q, 2'b00} +: ENT_W];
  assign slot_idx = slot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ctx_flat <= '0;
    else if (!run_en && cfg_we && addr_ok)
      ctx_flat[{cfg_addr, 2'b00} +: ENT_W] <= cfg_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          slot_q <= '0;
    else if (!run_en)    slot_q <= '0;
    else if (slot_q == LAST) slot_q <= '0;
    else                 slot_q <= slot_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out0_data  <= '0;
      out1_data  <= '0;
      out0_valid <= 1'b0;
      out1_valid <= 1'b0;
    end else if (run_en) begin
      out0_data  <= cur_ent[0] ? in1_data : in0_data;
      out0_valid <= cur_ent[1];
      out1_data  <= cur_ent[2] ? in1_data : in0_data;
      out1_valid <= cur_ent[3];
    end else begin
      out0_valid <= 1'b0;
      out1_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/tmx_sched_switch_chk.sv
module tmx_sched_switch_chk #(
  parameter int DATA_W    = 16,
  parameter int SCHED_LEN = 6,
  localparam int CNT_W    = (SCHED_LEN > 1) ? $clog2(SCHED_LEN) : 1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   run_en,
  input logic [DATA_W-1:0]      in0_data,
  input logic [DATA_W-1:0]      in1_data,
  input logic [DATA_W-1:0]      out0_data,
  input logic                   out0_valid,
  input logic [DATA_W-1:0]      out1_data,
  input logic                   out1_valid,
  input logic [CNT_W-1:0]       slot_idx,
  input logic [3:0]             cur_ent,
  input logic [4*SCHED_LEN-1:0] ctx_flat
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SCHED_LEN - 1);

  // R4
  slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> slot_idx == '0);
  // R4
  slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_en && slot_idx != LAST |=> slot_idx == $past(slot_idx) + 1'b1);
  // R5
  slot_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_en && slot_idx == LAST |=> slot_idx == '0);
  // R3
  ctx_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_en |=> $stable(ctx_flat));
  // R6
  out0_mux_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_en |=> out0_data == ($past(cur_ent[0]) ? $past(in1_data) : $past(in0_data)));
  // R6
  out1_mux_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_en |=> out1_data == ($past(cur_ent[2]) ? $past(in1_data) : $past(in0_data)));
  // R7
  idle_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> !out0_valid && !out1_valid && $stable(out0_data) && $stable(out1_data));
  // R7
  sched_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_en |=> out0_valid == $past(cur_ent[1]) && out1_valid == $past(cur_ent[3]));
endmodule

bind tmx_sched_switch tmx_sched_switch_chk #(.DATA_W(DATA_W), .SCHED_LEN(SCHED_LEN)) chk_i (
  .clk(clk), .rst_n(rst_n), .run_en(run_en),
  .in0_data(in0_data), .in1_data(in1_data),
  .out0_data(out0_data), .out0_valid(out0_valid),
  .out1_data(out1_data), .out1_valid(out1_valid),
  .slot_idx(slot_idx), .cur_ent(cur_ent), .ctx_flat(ctx_flat)
);

// File: tb/tmx_sched_switch_tb_top.sv
module tmx_sched_switch_tb_top;
  localparam int DW  = 16;
  localparam int LEN = 6;
  localparam int CW  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_en = 1'b0, cfg_we = 1'b0;
  logic [CW-1:0] cfg_addr = '0;
  logic [3:0] cfg_data = '0;
  logic [DW-1:0] in0_data = '0, in1_data = '0;
  logic [DW-1:0] out0_data, out1_data;
  logic out0_valid, out1_valid;
  logic [CW-1:0] slot_idx;

  int n_chk = 0, n_bad = 0;
  logic [3:0] ctx_m [8];
  int cnt_m = 0;
  logic [DW-1:0] e_d0 = '0, e_d1 = '0;
  logic e_v0 = 1'b0, e_v1 = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tmx_sched_switch #(.DATA_W(DW), .SCHED_LEN(LEN)) dut_i (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .in0_data(in0_data), .in1_data(in1_data),
    .out0_data(out0_data), .out0_valid(out0_valid),
    .out1_data(out1_data), .out1_valid(out1_valid),
    .slot_idx(slot_idx));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pick(input logic s, input logic [DW-1:0] a, input logic [DW-1:0] b);
    return s ? b : a;
  endfunction

  // one clock: drive at negedge, compare at the next negedge
  task automatic step(input bit run, input bit we, input int addr, input logic [3:0] dat,
                      input logic [DW-1:0] a, input logic [DW-1:0] b);
    logic [3:0] e;
    run_en = run; cfg_we = we; cfg_addr = CW'(addr); cfg_data = dat;
    in0_data = a; in1_data = b;
    check(slot_idx == CW'(cnt_m), (run && cnt_m == 0) ? "R5" : "R4", slot_idx, cnt_m);
    if (run) begin
      e = ctx_m[cnt_m];
      e_d0 = pick(e[0], a, b); e_v0 = e[1];
      e_d1 = pick(e[2], a, b); e_v1 = e[3];
      cnt_m = (cnt_m == LEN-1) ? 0 : cnt_m + 1;
    end else begin
      e_v0 = 1'b0; e_v1 = 1'b0;
      cnt_m = 0;
      if (we && addr < LEN) ctx_m[addr] = dat;   // R2 load, R9 out-of-range ignored
    end
    @(posedge clk); @(negedge clk);
    check(out0_data == e_d0, "R6", out0_data, e_d0);
    check(out1_data == e_d1, "R6", out1_data, e_d1);
    check(out0_valid == e_v0, "R7", out0_valid, e_v0);
    check(out1_valid == e_v1, "R7", out1_valid, e_v1);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    for (int i = 0; i < 8; i++) ctx_m[i] = 4'h0;
    #35 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!out0_valid && !out1_valid, "R1", {out0_valid, out1_valid}, 0);
    check(out0_data == 0 && out1_data == 0, "R1", out0_data, 0);
    check(slot_idx == 0, "R1", slot_idx, 0);
    // R1 empty context: running gives no valid words, both outputs follow in0
    for (int i = 0; i < LEN; i++) step(1, 0, 0, 0, DW'(16'h1000 + i), DW'(16'h2000 + i));
    step(0, 0, 0, 0, 0, 0);
    // R2 directed load; R8 broadcast in slot 2 (both pick in1), slot 3 both pick in0
    step(0, 1, 0, 4'b1011, 0, 0);
    step(0, 1, 1, 4'b1110, 0, 0);
    step(0, 1, 2, 4'b1111, 0, 0);
    step(0, 1, 3, 4'b1010, 0, 0);
    step(0, 1, 4, 4'b0010, 0, 0);
    step(0, 1, 5, 4'b1100, 0, 0);
    // R9 out-of-range writes change nothing
    step(0, 1, 6, 4'b0000, 0, 0);
    step(0, 1, 7, 4'b0101, 0, 0);
    // R5 wrap over several periods
    for (int i = 0; i < 3*LEN; i++) step(1, 0, 0, 0, DW'($urandom), DW'($urandom));
    // R3 writes during run are ignored
    for (int i = 0; i < 2*LEN; i++) step(1, 1, i % LEN, 4'b0000, DW'($urandom), DW'($urandom));
    // R4 counter held at zero while idle, restart from slot 0
    step(0, 0, 0, 0, 16'hAAAA, 16'h5555);
    step(0, 0, 0, 0, 16'hBBBB, 16'h6666);
    for (int i = 0; i < LEN+2; i++) step(1, 0, 0, 0, DW'($urandom), DW'($urandom));
    // constrained random mix
    for (int i = 0; i < 3000; i++) begin
      bit r;
      r = ($urandom % 4) != 0;
      step(r, ($urandom % 2) == 1, $urandom % 8, 4'($urandom), DW'($urandom), DW'($urandom));
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule